// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is a write-only serial port that loads a small set of configuration registers. A host holds the enable line low, toggles the serial clock and presents one data bit per falling clock edge. Every sixteen bits form one word: the first five bits to arrive give the register address and the remaining eleven give the register contents. Several words may be sent back to back within one enable window. Bits that are left over when the window closes are dropped, and the next window starts on a fresh word boundary.

The serial lines are sampled in the block's own clock domain, and they are assumed to be already synchronous to it, with each serial clock level held for at least one system clock. The stored contents are turned into decoded configuration outputs. A control flag in the mode register chooses whether the pin-controllable modes come from the registers or from external strap pins. Power-down is the OR of a strap pin and a register bit. A high level on the hardware reset input, or a write of the reset bit at address 0x00, returns every register to its default value of zero. The reset bit then clears itself.

Top module: `sercfg_port`

## Requirements
- R1: Falling edges of `sclk` that occur while `sen` is high neither shift data nor write any register.
- R2: A bit is taken from `sdata` in the system clock cycle in which `sclk` is first seen low after having been high. The value of `sdata` while `sclk` is high does not matter.
- R3: The 16th qualifying falling edge of a window writes the word, and so does every further 16th edge. Several words in one window are all written. The decoded outputs change on the second rising `clk` edge counted from the edge that sees the 16th fall.
- R4: When `sen` rises, any bits short of a whole word are discarded. The next window starts counting a new word from its first falling edge.
- R5: The word is sent MSB first. Word bits 15:11 are the address and bits 10:0 are the data. At address 0x0D the data bits are: 10 override, 7:5 fine gain, 4 offset-binary, 3 LSB-first, 2:1 lane mode, 0 coarse gain. At address 0x0A they are: 9:8 test pattern and 0 power-down.
- R6: When `hw_rst` is sampled high on a rising `clk` edge, all registers return to zero from that edge on, and any word being written at that edge is lost. A low `rst_n` clears the whole block synchronously.
- R7: A word to address 0x00 with data bit 0 set returns all registers to zero one clock after it is written. The reset bit clears itself. A word to address 0x00 with bit 0 clear has no effect.
- R8: While override is 1, the coarse gain, lane mode, LSB-first and offset-binary outputs follow the register fields. While override is 0, lane mode, LSB-first and offset-binary follow the strap pins, and coarse gain is 0.
- R9: `cfg_powerdown` is high whenever `pin_pdn` is high, or when the power-down register bit is set.
- R10: A word to an address other than 0x00, 0x0A or 0x0D changes no output.
- R11: `cfg_fine_gain` is the fine gain field saturated at 6, whatever the override setting. `cfg_pattern` is the pattern field taken directly from the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| hw_rst | input | 1 | Active-high register reset request |
| sen | input | 1 | Serial enable, active low |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdata | input | 1 | Serial data |
| pin_pdn | input | 1 | Strap: power-down request |
| pin_lane_mode | input | 2 | Strap: lane mode |
| pin_lsb_first | input | 1 | Strap: LSB-first order |
| pin_offset_bin | input | 1 | Strap: offset-binary format |
| cfg_coarse_gain | output | 1 | Coarse gain enabled |
| cfg_fine_gain | output | 3 | Fine gain in dB steps, 0 to 6 |
| cfg_lane_mode | output | 2 | Resolved lane mode |
| cfg_lsb_first | output | 1 | Resolved bit order |
| cfg_offset_bin | output | 1 | Resolved number format |
| cfg_pattern | output | 2 | Test pattern select |
| cfg_powerdown | output | 1 | Global power-down |
| cfg_override | output | 1 | Register control active |

## Verification
The hardest situations to reach from the ports are those where the word boundary and the enable window do not line up. One is a window that ends with a partial word and is followed at once by a full word. Another is a burst of clock edges sent while enable is high. Both would leave a shifted alignment behind without any visible error. The stimulus therefore sends seven extra bits after a word, closes the window and then sends a word whose decoded value is known. It also sends a complete word pattern with enable held high. For R2, one word is sent with the data line inverted during every high phase and again just after every sampling cycle, so only the exact sampling cycle yields the right value. A behavioural model driven by a bit queue is compared with every output on every clock, so the latency of each write is checked as well as its value.

// File: rtl/sercfg_pkg.sv
// Package: shared widths, register addresses, field positions and the
// decoded configuration record of the serial configuration port.
package sercfg_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 11;
    localparam int WORD_W = ADDR_W + DATA_W;
    localparam int FINE_W = 3;
    localparam int FINE_MAX = 6;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // Addresses the block decodes; 0x00 and the override position are fixed.
    localparam addr_t ADDR_SRST = 5'h00;
    localparam addr_t ADDR_PWR  = 5'h0A;
    localparam addr_t ADDR_MODE = 5'h0D;

    // Field positions inside the mode register.
    localparam int B_GAIN = 0;
    localparam int B_LANE = 1;   // two bits
    localparam int B_LSB  = 3;
    localparam int B_OBIN = 4;
    localparam int B_FINE = 5;   // FINE_W bits
    localparam int B_OVR  = 10;
    // Field positions inside the power register.
    localparam int B_PD   = 0;
    localparam int B_PAT  = 8;   // two bits
    localparam int B_SRST = 0;

    // Stored register fields.
    typedef struct packed {
        logic              ovr;
        logic              gain;
        logic [1:0]        lane;
        logic              lsb;
        logic              obin;
        logic [FINE_W-1:0] fine;
        logic              pd;
        logic [1:0]        pat;
    } regs_t;

    // Resolved configuration presented at the outputs.
    typedef struct packed {
        logic              coarse_gain;
        logic [FINE_W-1:0] fine_gain;
        logic [1:0]        lane_mode;
        logic              lsb_first;
        logic              offset_bin;
        logic [1:0]        pattern;
        logic              powerdown;
        logic              override;
    } cfg_t;
endpackage

// File: rtl/sercfg_shift.sv
// Module: serial word assembler.
// Finds falling edges of sclk in the clk domain and shifts sdata in while
// sen is low. It emits one word strobe on every 16th fall of a window.
// Assumes sen/sclk/sdata are synchronous to clk and that each sclk level
// lasts at least one clk cycle.
module sercfg_shift
    import sercfg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sen,
    input  logic         sclk,
    input  logic         sdata,
    output logic         word_vld,
    output logic [W-1:0] word
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic             sclk_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-2:0]     shreg_q;
    logic             fall;

    // A qualifying edge: sclk was high last cycle, is low now, window open.
    assign fall = sclk_q & ~sclk & ~sen;

    // Remember the previous sclk level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Bit counter and shift register; a high enable restarts alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (sen) begin
            cnt_q   <= '0;
        end else if (fall) begin
            shreg_q <= {shreg_q[W-3:0], sdata};
            cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Present a completed word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= fall && (cnt_q == LAST);
            if (fall && (cnt_q == LAST)) word <= {shreg_q, sdata};
        end
    end

    a_r1_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        sen |=> (cnt_q == '0));
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
endmodule

// File: rtl/sercfg_regs.sv
// Module: configuration register file.
// Decodes each assembled word into address and data and updates the
// addressed register. It also handles the hardware reset and the
// self-clearing software reset. Unknown addresses are dropped.
module sercfg_regs
    import sercfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_rst,
    input  logic          word_vld,
    input  logic [WORD_W-1:0] word,
    output regs_t         regs_q
);
    addr_t addr;
    data_t data;
    logic  hit_mode, hit_pwr, hit_srst;
    logic  srst_q;
    logic  clr;

    assign addr     = word[WORD_W-1:DATA_W];
    assign data     = word[DATA_W-1:0];
    assign hit_mode = word_vld && (addr == ADDR_MODE);
    assign hit_pwr  = word_vld && (addr == ADDR_PWR);
    assign hit_srst = word_vld && (addr == ADDR_SRST) && data[B_SRST];
    assign clr      = !rst_n || hw_rst || srst_q;

    // Software reset flag: set by a write, cleared on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst) srst_q <= 1'b0;
        else if (srst_q)      srst_q <= 1'b0;
        else                  srst_q <= hit_srst;
    end

    // Mode register fields.
    always_ff @(posedge clk) begin
        if (clr) begin
            regs_q.ovr  <= 1'b0;
            regs_q.gain <= 1'b0;
            regs_q.lane <= '0;
            regs_q.lsb  <= 1'b0;
            regs_q.obin <= 1'b0;
            regs_q.fine <= '0;
        end else if (hit_mode) begin
            regs_q.ovr  <= data[B_OVR];
            regs_q.gain <= data[B_GAIN];
            regs_q.lane <= data[B_LANE +: 2];
            regs_q.lsb  <= data[B_LSB];
            regs_q.obin <= data[B_OBIN];
            regs_q.fine <= data[B_FINE +: FINE_W];
        end
    end

    // Power and pattern register fields.
    always_ff @(posedge clk) begin
        if (clr) begin
            regs_q.pd  <= 1'b0;
            regs_q.pat <= '0;
        end else if (hit_pwr) begin
            regs_q.pd  <= data[B_PD];
            regs_q.pat <= data[B_PAT +: 2];
        end
    end

    a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q);
    a_r7_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (regs_q == '0));
    a_r6_hw_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst |=> (regs_q == '0));
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !hw_rst && !srst_q && addr != ADDR_MODE
         && addr != ADDR_PWR && addr != ADDR_SRST) |=> $stable(regs_q));
endmodule

// File: rtl/sercfg_resolve.sv
// Module: configuration resolver.
// Combines the stored fields with the strap pins. The override flag picks
// the source of the pin-controllable modes. Power-down is the OR of pin and
// register bit, and fine gain saturates. Purely combinational.
module sercfg_resolve
    import sercfg_pkg::*;
(
    input  regs_t      regs,
    input  logic       pin_pdn,
    input  logic [1:0] pin_lane_mode,
    input  logic       pin_lsb_first,
    input  logic       pin_offset_bin,
    output cfg_t       cfg
);
    localparam logic [FINE_W-1:0] FMAX = FINE_W'(FINE_MAX);

    // Select each output field from its source.
    always_comb begin
        cfg.override    = regs.ovr;
        cfg.coarse_gain = regs.ovr & regs.gain;
        cfg.lane_mode   = regs.ovr ? regs.lane : pin_lane_mode;
        cfg.lsb_first   = regs.ovr ? regs.lsb  : pin_lsb_first;
        cfg.offset_bin  = regs.ovr ? regs.obin : pin_offset_bin;
        cfg.fine_gain   = (regs.fine > FMAX) ? FMAX : regs.fine;
        cfg.pattern     = regs.pat;
        cfg.powerdown   = pin_pdn | regs.pd;
    end
endmodule

// File: rtl/sercfg_port.sv
// Module: serial configuration write port (top).
// Connects the word assembler, the register file and the resolver.
// Assumes the serial inputs are synchronous to clk.
module sercfg_port
    import sercfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst,
    input  logic       sen,
    input  logic       sclk,
    input  logic       sdata,
    input  logic       pin_pdn,
    input  logic [1:0] pin_lane_mode,
    input  logic       pin_lsb_first,
    input  logic       pin_offset_bin,
    output logic       cfg_coarse_gain,
    output logic [2:0] cfg_fine_gain,
    output logic [1:0] cfg_lane_mode,
    output logic       cfg_lsb_first,
    output logic       cfg_offset_bin,
    output logic [1:0] cfg_pattern,
    output logic       cfg_powerdown,
    output logic       cfg_override
);
    logic              word_vld;
    logic [WORD_W-1:0] word;
    regs_t             regs;
    cfg_t              cfg;

    sercfg_shift #(.W(WORD_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .sen(sen), .sclk(sclk), .sdata(sdata),
        .word_vld(word_vld), .word(word)
    );

    sercfg_regs regs_i (
        .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst),
        .word_vld(word_vld), .word(word), .regs_q(regs)
    );

    sercfg_resolve resolve_i (
        .regs(regs), .pin_pdn(pin_pdn), .pin_lane_mode(pin_lane_mode),
        .pin_lsb_first(pin_lsb_first), .pin_offset_bin(pin_offset_bin),
        .cfg(cfg)
    );

    assign cfg_coarse_gain = cfg.coarse_gain;
    assign cfg_fine_gain   = cfg.fine_gain;
    assign cfg_lane_mode   = cfg.lane_mode;
    assign cfg_lsb_first   = cfg.lsb_first;
    assign cfg_offset_bin  = cfg.offset_bin;
    assign cfg_pattern     = cfg.pattern;
    assign cfg_powerdown   = cfg.powerdown;
    assign cfg_override    = cfg.override;

    a_r8_gain_needs_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_coarse_gain |-> regs.ovr);
    a_r8_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !regs.ovr |-> (cfg_lane_mode == pin_lane_mode));
    a_r9_pin_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pdn |-> cfg_powerdown);
    a_r11_fine_sat: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fine_gain <= 3'd6);
endmodule

// File: tb/sercfg_port_tb.sv
// Bench: drives serial words and strap pins. It keeps a behavioural model
// built from a bit queue and compares every output with it on each clock.
// Directed checks with fixed expected values are added on top.
module sercfg_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0, hw_rst = 1'b0;
    logic sen = 1'b1, sclk = 1'b0, sdata = 1'b0;
    logic pin_pdn = 1'b0, pin_lsb_first = 1'b0, pin_offset_bin = 1'b0;
    logic [1:0] pin_lane_mode = 2'b00;
    logic       cfg_coarse_gain, cfg_lsb_first, cfg_offset_bin;
    logic       cfg_powerdown, cfg_override;
    logic [2:0] cfg_fine_gain;
    logic [1:0] cfg_lane_mode, cfg_pattern;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    sercfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .sen(sen), .sclk(sclk),
        .sdata(sdata), .pin_pdn(pin_pdn), .pin_lane_mode(pin_lane_mode),
        .pin_lsb_first(pin_lsb_first), .pin_offset_bin(pin_offset_bin),
        .cfg_coarse_gain(cfg_coarse_gain), .cfg_fine_gain(cfg_fine_gain),
        .cfg_lane_mode(cfg_lane_mode), .cfg_lsb_first(cfg_lsb_first),
        .cfg_offset_bin(cfg_offset_bin), .cfg_pattern(cfg_pattern),
        .cfg_powerdown(cfg_powerdown), .cfg_override(cfg_override)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural model ----------------
    bit        q[$];
    bit        prev_sclk = 0, pend = 0, m_srst = 0;
    bit [15:0] pword;
    bit [10:0] m_mode = 0, m_pwr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); prev_sclk = 0; pend = 0; m_srst = 0; m_mode = 0; m_pwr = 0;
        end else begin
            if (hw_rst || m_srst) begin
                m_mode = 0; m_pwr = 0; m_srst = 0;
            end else if (pend) begin
                case (pword[15:11])
                    5'h0D: m_mode = pword[10:0];
                    5'h0A: m_pwr  = pword[10:0];
                    5'h00: m_srst = pword[0];
                    default: ;
                endcase
            end
            pend = 0;
            if (sen) q.delete();
            else if (prev_sclk && !sclk) begin
                q.push_back(sdata);
                if (q.size() == 16) begin
                    foreach (q[i]) pword[15-i] = q[i];
                    pend = 1;
                    q.delete();
                end
            end
            prev_sclk = sclk;
        end
    end

    // Compare every output with the model just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            automatic bit ovr = m_mode[10];
            automatic int fine = (m_mode[7:5] > 6) ? 6 : m_mode[7:5];
            check("R3/R8 coarse gain", cfg_coarse_gain, ovr & m_mode[0]);
            check("R3/R11 fine gain", cfg_fine_gain, fine);
            check("R3/R8 lane mode", cfg_lane_mode, ovr ? m_mode[2:1] : pin_lane_mode);
            check("R3/R8 lsb first", cfg_lsb_first, ovr ? m_mode[3] : pin_lsb_first);
            check("R3/R8 offset bin", cfg_offset_bin, ovr ? m_mode[4] : pin_offset_bin);
            check("R3/R11 pattern", cfg_pattern, m_pwr[9:8]);
            check("R3/R9 powerdown", cfg_powerdown, pin_pdn | m_pwr[0]);
            check("R3/R8 override", cfg_override, ovr);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_bit(logic b, bit skew);
        sclk = 1'b1; sdata = skew ? ~b : b;
        tick(2);
        sclk = 1'b0; sdata = b;
        tick(1);
        if (skew) sdata = ~b;
        tick(1);
    endtask

    task automatic send_bits(logic [15:0] w, int n, bit skew);
        for (int i = n - 1; i >= 0; i--) fall_bit(w[i], skew);
    endtask

    task automatic open_win();  sen = 1'b0; tick(2); endtask
    task automatic close_win(); sen = 1'b1; tick(4); endtask

    task automatic write_word(logic [15:0] w);
        open_win(); send_bits(w, 16, 0); close_win();
    endtask

    task automatic check_all(string tag, int g, int f, int l, int lsb, int ob,
                             int pat, int pd, int ov);
        check({tag, " gain"}, cfg_coarse_gain, g);
        check({tag, " fine"}, cfg_fine_gain, f);
        check({tag, " lane"}, cfg_lane_mode, l);
        check({tag, " lsb"}, cfg_lsb_first, lsb);
        check({tag, " obin"}, cfg_offset_bin, ob);
        check({tag, " pattern"}, cfg_pattern, pat);
        check({tag, " pd"}, cfg_powerdown, pd);
        check({tag, " ovr"}, cfg_override, ov);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R3 watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check_all("R6 reset", 0, 0, 0, 0, 0, 0, 0, 0);

        // R8: override clear, modes follow pins, gain 0.
        pin_lane_mode = 2'b11; pin_lsb_first = 1'b1; pin_offset_bin = 1'b0;
        tick(1);
        check_all("R8 pins", 0, 0, 3, 1, 0, 0, 0, 0);

        // R5/R8: mode word with override set (0x0D, data 0x4B3).
        write_word(16'h6800 | 16'h04B3);
        check_all("R5 R8 mode", 1, 5, 1, 0, 1, 0, 0, 1);

        // R3/R11: two words in one window; fine 7 saturates to 6, override off.
        open_win();
        send_bits(16'h5000 | 16'h0201, 16, 0);
        send_bits(16'h6800 | 16'h00E8, 16, 0);
        close_win();
        check_all("R3 R11 burst", 0, 6, 3, 1, 0, 2, 1, 0);

        // R1: a full word clocked with enable high changes nothing.
        send_bits(16'h6800 | 16'h07FF, 16, 0);
        tick(4);
        check_all("R1 enable high", 0, 6, 3, 1, 0, 2, 1, 0);

        // R4: a word plus seven stray bits, then a fresh aligned word.
        open_win();
        send_bits(16'h5000 | 16'h0001, 16, 0);
        send_bits(16'h007F, 7, 0);
        close_win();
        check_all("R4 partial", 0, 6, 3, 1, 0, 0, 1, 0);
        write_word(16'h5000 | 16'h0100);
        check_all("R4 realigned", 0, 6, 3, 1, 0, 1, 0, 0);

        // R10: unmapped addresses; R7: address 0 with bit 0 clear.
        write_word(16'hF800 | 16'h07FF);
        write_word(16'h0800 | 16'h07FF);
        write_word(16'h0000 | 16'h0002);
        check_all("R10 R7 no effect", 0, 6, 3, 1, 0, 1, 0, 0);

        // R9: pin power-down with register bit clear.
        pin_pdn = 1'b1; tick(1);
        check("R9 pin pdn", cfg_powerdown, 1);
        pin_pdn = 1'b0; tick(1);
        check("R9 pin released", cfg_powerdown, 0);

        // R2: data inverted outside the sampling cycle.
        open_win(); send_bits(16'h6800 | 16'h04B3, 16, 1); close_win();
        check_all("R2 skewed data", 1, 5, 1, 0, 1, 1, 0, 1);

        // R7: software reset returns defaults.
        pin_lane_mode = 2'b00; pin_lsb_first = 1'b0;
        write_word(16'h0001);
        check_all("R7 soft reset", 0, 0, 0, 0, 0, 0, 0, 0);

        // R6: hardware reset pulse.
        write_word(16'h6800 | 16'h04B3);
        write_word(16'h5000 | 16'h0301);
        check_all("R6 before", 1, 5, 1, 0, 1, 3, 1, 1);
        hw_rst = 1'b1; tick(1); hw_rst = 1'b0; tick(2);
        check_all("R6 hw reset", 0, 0, 0, 0, 0, 0, 0, 0);

        tick(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule